// File: doc/BRIEF.md
# Page Program Sequencer

This block gathers the data bytes of one serial memory write command into a four-slot page buffer. It then starts a self-timed programming cycle, provided chip select rises cleanly between bytes and the protection logic allows the write. The command decoder supplies the start address once the address phase has ended. After that it strobes every received bit and marks the last bit of each byte together with the byte value. The sequencer tracks the write position inside the four-byte page. It keeps a mask of the slots that were actually filled and decides at the chip-select rise whether to commit the write or drop it.

A committed cycle keeps `busy_o` high for `PROG_CYC` clocks. During its first four clocks the buffered bytes go out on the array write port, one slot per clock, in ascending slot order. Only filled slots are written, and no erase step comes first. In the last busy clock, `done_o` pulses so the protection logic can clear its write enable latch. A status-register program request uses the same timer. It produces the same busy window and done pulse, flagged by `sr_cyc_o`, and issues no array writes.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sr_cyc_o` and `arr_we_o` are all 0.
- R2: A data byte is stored at the page held in address bits [AW-1:2] of the start address, in the slot given by a 2-bit pointer. The pointer is loaded from address bits [1:0] and advances by one per byte, wrapping from 3 to 0. The upper address bits never change within one command.
- R3: When more than four bytes arrive, a later byte replaces the earlier byte in the same slot, and only the last value of each slot is programmed.
- R4: During a page cycle, slot s is written in busy clock s (s = 0..3), at address {page, s}, only when slot s received a byte. No array write occurs outside `busy_o`.
- R5: If chip select rises after one or more bits of an incomplete byte, no cycle starts and no array write occurs.
- R6: If chip select rises before any data byte was received, no cycle starts.
- R7: If `permit_i` is 0 when chip select rises, no cycle starts.
- R8: A committed cycle raises `busy_o` in the clock after the chip-select rise (or after the status request) and holds it for exactly `PROG_CYC` clocks.
- R9: `done_o` is high for exactly one clock per cycle, namely the last clock in which `busy_o` is high.
- R10: While `busy_o` is high, `start_i`, `bit_stb_i`, `byte_vld_i`, `cs_rise_i` and `sr_go_i` have no effect. They neither extend the cycle, add array writes, nor arm a later commit.
- R11: `sr_go_i` while idle starts a cycle of `PROG_CYC` clocks with `sr_cyc_o` high throughout and no array writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address phase of a write command complete; loads `addr_i` |
| addr_i | input | AW | Start address of the write |
| bit_stb_i | input | 1 | One serial data bit received |
| byte_vld_i | input | 1 | Last bit of a byte received; `byte_i` is valid |
| byte_i | input | 8 | Received data byte |
| cs_rise_i | input | 1 | Chip select went inactive |
| permit_i | input | 1 | Protection logic allows this write |
| sr_go_i | input | 1 | Start a status-register program cycle |
| busy_o | output | 1 | Programming cycle in progress |
| done_o | output | 1 | One-clock pulse in the last busy clock |
| sr_cyc_o | output | 1 | Current cycle is a status-register cycle |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | AW | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The bench starts writes at slot 1 and at slot 2 with three bytes, so that the pointer wraps 3 to 0. A design that carried the increment into the page bits would write outside the page. Six bytes from slot 0 check replacement: a wrong design would program the first bytes or write a slot twice. Chip-select rises after three stray bits, with no data, and with the permit low must all leave `busy_o` at 0. A design that missed one of these would start a cycle that the scoreboard reports as an unexpected write. Stimulus injected in the middle of a cycle, followed by a bare chip-select rise, catches a design that re-arms or restarts its timer while busy.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOTS  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BUSY
  } seq_st_e;

  typedef enum logic {
    CYC_PAGE,
    CYC_STAT
  } cyc_kind_e;
endpackage

// File: rtl/page_buf.sv
module page_buf
  import page_prog_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [PW-1:0]     rd_slot_i,
  output logic [AW-PW-1:0]  page_o,
  output logic [SLOTS-1:0]  mask_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              has_data_o
);
  logic [PW-1:0]     ptr_q;
  logic [AW-PW-1:0]  page_q;
  logic [BYTE_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (load_i) begin
      ptr_q  <= addr_i[PW-1:0];
      page_q <= addr_i[AW-1:PW];
    end else if (wr_i) begin
      ptr_q  <= ptr_q + 1'b1;  // low bits only, wraps in page
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else if (load_i) begin
        mask_q[g] <= 1'b0;
      end else if (wr_i && ptr_q == PW'(g)) begin
        data_q[g] <= data_i;
        mask_q[g] <= 1'b1;
      end
    end
  end

  assign page_o     = page_q;
  assign mask_o     = mask_q;
  assign rd_data_o  = data_q[rd_slot_i];
  assign has_data_o = |mask_q;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYC = 5000,
  localparam int CW = $clog2(PROG_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign last_o = busy_q && cnt_q == LAST;
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import page_prog_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PROG_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              bit_stb_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              permit_i,
  input  logic              sr_go_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sr_cyc_o,
  output logic              arr_we_o,
  output logic [AW-1:0]     arr_addr_o,
  output logic [BYTE_W-1:0] arr_data_o
);
  localparam int PW = $clog2(SLOTS);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam logic [CW-1:0] SLOT_LIM = CW'(SLOTS);

  seq_st_e   st_q;
  cyc_kind_e kind_q;
  logic      partial_q;

  logic [AW-PW-1:0]  page;
  logic [SLOTS-1:0]  mask;
  logic [BYTE_W-1:0] rd_data;
  logic              has_data;
  logic              tmr_busy, tmr_last;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     slot;
  logic              commit_ok, page_go, stat_go;

  assign slot      = cnt[PW-1:0];
  assign commit_ok = !partial_q && has_data && permit_i;
  assign page_go   = st_q == ST_ARMED && cs_rise_i && commit_ok;
  assign stat_go   = st_q == ST_IDLE && sr_go_i && !start_i;

  page_buf #(.AW(AW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i && st_q != ST_BUSY),
    .addr_i     (addr_i),
    .wr_i       (st_q == ST_ARMED && byte_vld_i),
    .data_i     (byte_i),
    .rd_slot_i  (slot),
    .page_o     (page),
    .mask_o     (mask),
    .rd_data_o  (rd_data),
    .has_data_o (has_data)
  );

  prog_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (page_go || stat_go),
    .busy_o (tmr_busy),
    .cnt_o  (cnt),
    .last_o (tmr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= CYC_PAGE;
      partial_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_ARMED;
            partial_q <= 1'b0;
          end else if (stat_go) begin
            st_q   <= ST_BUSY;
            kind_q <= CYC_STAT;
          end
        end
        ST_ARMED: begin
          if (cs_rise_i) begin
            st_q   <= page_go ? ST_BUSY : ST_IDLE;
            kind_q <= CYC_PAGE;
          end else if (start_i) begin
            partial_q <= 1'b0;
          end else if (byte_vld_i) begin
            partial_q <= 1'b0;
          end else if (bit_stb_i) begin
            partial_q <= 1'b1;  // stray bits after last full byte
          end
        end
        ST_BUSY: begin
          if (tmr_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = tmr_busy;
  assign done_o     = tmr_last;
  assign sr_cyc_o   = tmr_busy && kind_q == CYC_STAT;
  assign arr_we_o   = tmr_busy && kind_q == CYC_PAGE && cnt < SLOT_LIM && mask[slot];
  assign arr_addr_o = {page, slot};
  assign arr_data_o = rd_data;
endmodule

// File: rtl/page_prog_chk.sv
module page_prog_chk #(
  parameter int AW       = 8,
  parameter int PROG_CYC = 5000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_rise_i,
  input logic          sr_go_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          sr_cyc_o,
  input logic          arr_we_o,
  input logic [AW-1:0] arr_addr_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o); // R4

  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[1:0] > $past(arr_addr_o[1:0])); // R4

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[AW-1:2] == $past(arr_addr_o[AW-1:2])); // R2

  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i || sr_go_i)); // R8

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == PROG_CYC); // R8

  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9

  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9

  AST_STAT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_cyc_o |-> !arr_we_o); // R11
endmodule

bind page_prog_seq page_prog_chk #(.AW(AW), .PROG_CYC(PROG_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_rise_i  (cs_rise_i),
  .sr_go_i    (sr_go_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sr_cyc_o   (sr_cyc_o),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o)
);

// File: tb/sim_page_prog_seq.sv
`timescale 1ns/1ps
module sim_page_prog_seq;
  localparam int AW = 8;
  localparam int PC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 0, bit_stb_i = 0, byte_vld_i = 0, cs_rise_i = 0;
  logic          permit_i = 1, sr_go_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    byte_i = '0;
  logic          busy_o, done_o, sr_cyc_o, arr_we_o;
  logic [AW-1:0] arr_addr_o;
  logic [7:0]    arr_data_o;

  int checks = 0;
  int fails  = 0;

  logic [AW+7:0] exp_q[$];
  logic [7:0]    m_data [4];
  logic [3:0]    m_mask;
  logic [AW-3:0] m_page;
  int            m_ptr;

  always #10 clk = ~clk;

  page_prog_seq #(.AW(AW), .PROG_CYC(PC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_i(addr_i),
    .bit_stb_i(bit_stb_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .cs_rise_i(cs_rise_i), .permit_i(permit_i), .sr_go_i(sr_go_i),
    .busy_o(busy_o), .done_o(done_o), .sr_cyc_o(sr_cyc_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare every array write
  always @(negedge clk) begin
    if (rst_n && arr_we_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: unexpected write actual %0h:%0h expected none",
                 arr_addr_o, arr_data_o);
      end else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        if ({arr_addr_o, arr_data_o} != e) begin
          fails++;
          $display("FAIL R2/R3/R4: write actual %0h expected %0h",
                   {arr_addr_o, arr_data_o}, e);
        end
      end
    end
  end

  task automatic do_start(input logic [AW-1:0] a);
    @(negedge clk); start_i = 1; addr_i = a;
    @(negedge clk); start_i = 0;
    m_page = a[AW-1:2]; m_ptr = int'(a[1:0]); m_mask = '0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bit_stb_i = 1; byte_vld_i = (i == 7); byte_i = b;
    end
    @(negedge clk); bit_stb_i = 0; byte_vld_i = 0;
    m_data[m_ptr] = b; m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 4;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_stb_i = 1;
    end
    @(negedge clk); bit_stb_i = 0;
  endtask

  task automatic measure(input string tag, input int exp_len, input bit poke,
                         input bit exp_sr);
    int cnt = 0, dones = 0, done_at = -1, sr_bad = 0;
    for (int i = 0; i < PC + 4; i++) begin
      if (busy_o) cnt++;
      if (done_o) begin dones++; done_at = cnt; end
      if (exp_sr && busy_o && !sr_cyc_o) sr_bad++;
      if (poke && i == 5) begin
        start_i = 1; addr_i = 8'h00; bit_stb_i = 1; byte_vld_i = 1; byte_i = 8'hEE;
      end
      if (poke && i == 6) begin
        start_i = 0; bit_stb_i = 0; byte_vld_i = 0; cs_rise_i = 1; sr_go_i = 1;
      end
      if (poke && i == 7) begin cs_rise_i = 0; sr_go_i = 0; end
      @(negedge clk);
    end
    chk({tag, " busy length"}, cnt, exp_len);
    chk("R9 done count", dones, exp_len != 0 ? 1 : 0);
    if (exp_len != 0) chk("R9 done in last busy clock", done_at, exp_len);
    if (exp_sr) chk("R11 sr_cyc during busy", sr_bad, 0);
    chk("R4 pending writes", exp_q.size(), 0);
  endtask

  task automatic cs_commit(input string tag, input bit go, input bit poke);
    if (go)
      for (int s = 0; s < 4; s++)
        if (m_mask[s]) exp_q.push_back({m_page, 2'(s), m_data[s]});
    @(negedge clk); cs_rise_i = 1;
    @(negedge clk); cs_rise_i = 0;
    measure(tag, go ? PC : 0, poke, 1'b0);
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 sr_cyc", sr_cyc_o, 0);
    chk("R1 we", arr_we_o, 0);

    // R2 R4: two bytes from slot 1
    do_start(8'h41); send_byte(8'hA1); send_byte(8'hA2);
    cs_commit("R8", 1, 0);

    // R2: pointer wraps 3->0, page fixed
    do_start(8'h86); send_byte(8'hB0); send_byte(8'hB1); send_byte(8'hB2);
    cs_commit("R8", 1, 0);

    // R3: six bytes, slots 0 and 1 replaced
    do_start(8'h10);
    send_byte(8'hC0); send_byte(8'hC1); send_byte(8'hC2);
    send_byte(8'hC3); send_byte(8'hC4); send_byte(8'hC5);
    cs_commit("R8", 1, 0);

    // R5: stray bits after a full byte abort the write
    do_start(8'h20); send_byte(8'hD0); send_bits(3);
    cs_commit("R5", 0, 0);
    do_start(8'h20); send_byte(8'hD1);
    cs_commit("R8", 1, 0);

    // R6: no data byte
    do_start(8'h30);
    cs_commit("R6", 0, 0);

    // R7: permit low
    do_start(8'h34); send_byte(8'hE0);
    permit_i = 0;
    cs_commit("R7", 0, 0);
    permit_i = 1;

    // R11: status cycle
    @(negedge clk); sr_go_i = 1;
    @(negedge clk); sr_go_i = 0;
    measure("R11", PC, 0, 1);

    // R10: inputs during busy are ignored
    do_start(8'hF3); send_byte(8'h5A);
    cs_commit("R10", 1, 1);
    cs_commit("R10", 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule